// File: doc/BRIEF.md
# Chained FIFO Slice Controller

This block is the control logic of one FIFO slice. Several identical slices can be linked in a ring to form one deeper FIFO. The slice keeps a write address and a read address for its own 512-entry memory, the number of entries it currently holds, and two tokens: one for writing and one for reading. It accepts a write only while it holds the write token, and it offers a read only while it holds the read token. When the slice uses its top location for a write or for a read, it gives up that token and sends a one-cycle pulse on `xout_o`. A kind bit goes with the pulse to say which token is being passed. The next slice takes the token when that pulse arrives on its `xin_i`. After reset, only the slice whose `first_n_i` is low holds the two tokens.

A strap input, `solo_i`, puts the slice in stand-alone mode. In that mode the slice ignores the tokens and the chain input, `xout_o` becomes a half-full indication, and a retransmit input rewinds the read address. Retransmit has no effect when the slice is chained.

The two data directions use valid/ready handshakes. A write completes on a clock edge where `wr_valid_i` and `wr_ready_o` are both high. A read completes on a clock edge where `rd_valid_o` and `rd_ready_i` are both high. The upstream source must hold its item while `wr_ready_o` is low, and the downstream sink may hold `rd_ready_i` low for any number of cycles. The memory array is outside this block. It writes at `wr_addr_o` on each completed write and reads at `rd_addr_o`.

Top module: `fx_chain_slice`

## Requirements
- R1: Reset is synchronous and active low. After reset, a slice with `first_n_i` low holds both tokens and a slice with `first_n_i` high holds neither. Both addresses and the fill level are 0 after reset, so `rd_valid_o` is 0, and `wr_ready_o` equals the write token.
- R2: `wr_ready_o` is high exactly when (`solo_i` or the write token is held) and the slice is not full and not (`solo_i` and `rt_i`). Each completed write advances `wr_addr_o` by one, and the address wraps from 511 to 0.
- R3: `rd_valid_o` is high exactly when (`solo_i` or the read token is held) and the fill level is nonzero and not (`solo_i` and `rt_i`). Each completed read advances `rd_addr_o` by one, and the address wraps from 511 to 0.
- R4: In chained mode, a write completed at `wr_addr_o` = 511 clears the write token. It also drives `xout_o` high with `xout_kind_o` = 0 for exactly the next cycle.
- R5: In chained mode, a read completed at `rd_addr_o` = 511 clears the read token. It also drives `xout_o` high with `xout_kind_o` = 1 for exactly the next cycle.
- R6: In chained mode, `xin_i` high at a clock edge grants a token from that edge on. `xin_kind_i` = 0 grants the write token and `xin_kind_i` = 1 grants the read token.
- R7: A chained slice that does not hold the write token ignores `wr_valid_i`, and one that does not hold the read token ignores `rd_ready_i`. Its addresses stay unchanged and it sends no pulse.
- R8: With `solo_i` high, `xout_o` is high exactly when the fill level exceeds 256. `xout_kind_o` is 0, and wrapping an address sends no pulse.
- R9: With `solo_i` high, `rt_i` high at an edge sets `rd_addr_o` to 0 and sets the fill level to the number of writes since reset, limited to 512. With `solo_i` low, `rt_i` has no effect.
- R10: After 512 writes with no reads, the slice is full and `wr_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| solo_i | input | 1 | Stand-alone strap: 1 = single slice, 0 = chained |
| first_n_i | input | 1 | Low marks the slice that holds both tokens after reset |
| xin_i | input | 1 | Token pulse from the previous slice |
| xin_kind_i | input | 1 | Token kind with `xin_i`: 0 = write, 1 = read |
| rt_i | input | 1 | Retransmit request (stand-alone mode only) |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Slice can accept a write |
| rd_ready_i | input | 1 | Consumer accepts a read |
| rd_valid_o | output | 1 | Slice offers a read |
| wr_addr_o | output | 9 | Memory write address |
| rd_addr_o | output | 9 | Memory read address |
| xout_o | output | 1 | Token pulse to the next slice, or half-full flag in stand-alone mode |
| xout_kind_o | output | 1 | Kind of the token in the outgoing pulse |

## Verification
A token register stuck high or stuck low shows up in the same cycle as a wrong `wr_ready_o` or `rd_valid_o`. Because the bench drives strobes while the slice lacks a token, it also shows up as a moving address. An address that moves too early or too late puts the token pulse on the wrong cycle. The scoreboard compares each pulse against the cycle in which it was expected, so an off-by-one in the last-location detection is caught. A wrong fill level shows up at the half-full output and at the full point as soon as the level crosses 256 or reaches 512. A faulty retransmit reload shows up at the first sample after the retransmit request.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int unsigned SLICE_DEPTH = 512;
  typedef enum logic {TOK_WR = 1'b0, TOK_RD = 1'b1} tok_kind_e;
endpackage

// File: rtl/fx_ring_ptr.sv
module fx_ring_ptr #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          zero_i,
  output logic [AW-1:0] ptr_o,
  output logic          last_o
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  assign last_o = (ptr_q == TOP);
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || zero_i)
      ptr_q <= '0;
    else if (step_i)
      ptr_q <= last_o ? '0 : ptr_q + AW'(1);
  end
endmodule

// File: rtl/fx_token_cell.sv
module fx_token_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic first_i,
  input  logic take_i,
  input  logic drop_i,
  output logic held_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      held_o <= first_i;
    else if (drop_i)
      held_o <= 1'b0;
    else if (take_i)
      held_o <= 1'b1;
  end
endmodule

// File: rtl/fx_level.sv
module fx_level #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic          reload_i,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          over_half_o
);
  localparam logic [LW-1:0] FULLV = LW'(DEPTH);
  localparam logic [LW-1:0] HALFV = LW'(DEPTH / 2);

  logic [LW-1:0] level_q;
  logic [LW-1:0] written_q;

  assign level_o     = level_q;
  assign full_o      = (level_q == FULLV);
  assign empty_o     = (level_q == '0);
  assign over_half_o = (level_q > HALFV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q   <= '0;
      written_q <= '0;
    end else begin
      if (inc_i && written_q != FULLV)
        written_q <= written_q + LW'(1);
      if (reload_i)
        level_q <= written_q;
      else begin
        case ({inc_i, dec_i})
          2'b10:   level_q <= level_q + LW'(1);
          2'b01:   level_q <= level_q - LW'(1);
          default: level_q <= level_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/fx_pass_pulse.sv
module fx_pass_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic pass_wr_i,
  input  logic pass_rd_i,
  output logic pulse_o,
  output logic kind_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_o <= 1'b0;
      kind_o  <= fx_pkg::TOK_WR;
    end else begin
      pulse_o <= pass_wr_i | pass_rd_i;
      kind_o  <= pass_wr_i ? fx_pkg::TOK_WR : fx_pkg::TOK_RD;
    end
  end
endmodule

// File: rtl/fx_chain_slice.sv
module fx_chain_slice #(
  parameter  int unsigned DEPTH = fx_pkg::SLICE_DEPTH,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          solo_i,
  input  logic          first_n_i,
  input  logic          xin_i,
  input  logic          xin_kind_i,
  input  logic          rt_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  logic          rd_ready_i,
  output logic          rd_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          xout_o,
  output logic          xout_kind_o
);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [1:0]    held, take, drop;
  logic          wr_fire, rd_fire, wr_last, rd_last, rewind;
  logic          full, empty, over_half, pulse, pulse_kind;
  logic [LW-1:0] level;

  assign rewind     = solo_i & rt_i;
  assign wr_ready_o = (solo_i | held[fx_pkg::TOK_WR]) & ~full  & ~rewind;
  assign rd_valid_o = (solo_i | held[fx_pkg::TOK_RD]) & ~empty & ~rewind;
  assign wr_fire    = wr_valid_i & wr_ready_o;
  assign rd_fire    = rd_ready_i & rd_valid_o;

  assign take[fx_pkg::TOK_WR] = ~solo_i & xin_i & (xin_kind_i == fx_pkg::TOK_WR);
  assign take[fx_pkg::TOK_RD] = ~solo_i & xin_i & (xin_kind_i == fx_pkg::TOK_RD);
  assign drop[fx_pkg::TOK_WR] = ~solo_i & wr_fire & wr_last;
  assign drop[fx_pkg::TOK_RD] = ~solo_i & rd_fire & rd_last;

  for (genvar k = 0; k < 2; k++) begin : g_tok
    fx_token_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .first_i(~first_n_i),
      .take_i (take[k]),
      .drop_i (drop[k]),
      .held_o (held[k])
    );
  end

  fx_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk   (clk),
    .rst_n (rst_n),
    .step_i(wr_fire),
    .zero_i(1'b0),
    .ptr_o (wr_addr_o),
    .last_o(wr_last)
  );

  fx_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk   (clk),
    .rst_n (rst_n),
    .step_i(rd_fire),
    .zero_i(rewind),
    .ptr_o (rd_addr_o),
    .last_o(rd_last)
  );

  fx_level #(.DEPTH(DEPTH), .LW(LW)) u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (wr_fire),
    .dec_i      (rd_fire),
    .reload_i   (rewind),
    .level_o    (level),
    .full_o     (full),
    .empty_o    (empty),
    .over_half_o(over_half)
  );

  fx_pass_pulse u_pass (
    .clk      (clk),
    .rst_n    (rst_n),
    .pass_wr_i(drop[fx_pkg::TOK_WR]),
    .pass_rd_i(drop[fx_pkg::TOK_RD]),
    .pulse_o  (pulse),
    .kind_o   (pulse_kind)
  );

  assign xout_o      = solo_i ? over_half : pulse;
  assign xout_kind_o = solo_i ? fx_pkg::TOK_WR : pulse_kind;
endmodule

// File: rtl/fx_chain_slice_chk.sv
module fx_chain_slice_chk #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          solo_i,
  input logic          xin_i,
  input logic          rt_i,
  input logic          wr_valid_i,
  input logic          wr_ready_o,
  input logic          rd_ready_i,
  input logic          rd_valid_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          xout_o,
  input logic          xout_kind_o
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  // R2
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_ready_o && wr_addr_o != TOP) |=> (wr_addr_o == $past(wr_addr_o) + AW'(1)));

  // R4
  wr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!solo_i && wr_valid_i && wr_ready_o && wr_addr_o == TOP) |=> (xout_o && !xout_kind_o && !wr_ready_o));

  // R5
  rd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!solo_i && rd_ready_i && rd_valid_o && rd_addr_o == TOP) |=> (xout_o && xout_kind_o && !rd_valid_o));

  // R7
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!solo_i && !wr_ready_o && !xin_i) |=> $stable(wr_addr_o));

  // R8
  solo_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    solo_i |-> !xout_kind_o);

  // R9
  rewind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (solo_i && rt_i) |-> (!wr_ready_o && !rd_valid_o));

  // R9
  rewind_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (solo_i && rt_i) |=> (rd_addr_o == '0));
endmodule

bind fx_chain_slice fx_chain_slice_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .solo_i     (solo_i),
  .xin_i      (xin_i),
  .rt_i       (rt_i),
  .wr_valid_i (wr_valid_i),
  .wr_ready_o (wr_ready_o),
  .rd_ready_i (rd_ready_i),
  .rd_valid_o (rd_valid_o),
  .wr_addr_o  (wr_addr_o),
  .rd_addr_o  (rd_addr_o),
  .xout_o     (xout_o),
  .xout_kind_o(xout_kind_o)
);

// File: tb/test_fx_chain_slice.sv
module test_fx_chain_slice;
  logic clk = 1'b0;
  logic rst_n, solo, first_n, xin, xin_kind, rt, wr_valid, rd_ready;
  logic wr_ready, rd_valid, xout, xout_kind;
  logic [8:0] wr_addr, rd_addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int bw, br;
  bit done = 1'b0;

  int exp_kind[$];
  int exp_cyc[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fx_chain_slice i_fx_chain_slice (
    .clk(clk), .rst_n(rst_n), .solo_i(solo), .first_n_i(first_n),
    .xin_i(xin), .xin_kind_i(xin_kind), .rt_i(rt),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .rd_ready_i(rd_ready), .rd_valid_o(rd_valid),
    .wr_addr_o(wr_addr), .rd_addr_o(rd_addr),
    .xout_o(xout), .xout_kind_o(xout_kind)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: every chained token pulse must match the next expected entry.
  always @(negedge clk) begin
    if (rst_n && !solo && xout) begin
      if (exp_kind.size() == 0) begin
        chk(1'b0, "R7 unexpected pulse", xout_kind, -1);
      end else begin
        int k, c;
        k = exp_kind.pop_front();
        c = exp_cyc.pop_front();
        chk(xout_kind == k[0], "R4/R5 pulse kind", xout_kind, k);
        chk(cyc == c, "R4/R5 pulse cycle", cyc, c);
      end
    end
  end

  task automatic do_reset(input bit s, input bit f);
    solo = s; first_n = f; xin = 0; xin_kind = 0; rt = 0;
    wr_valid = 0; rd_ready = 0; rst_n = 0;
    bw = 0; br = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  // Driver: each write is accepted at the next edge; predicted pulses are queued.
  task automatic write_n(input int n);
    wr_valid = 1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (!solo && bw == 511) begin
        exp_kind.push_back(0);
        exp_cyc.push_back(cyc);
      end
      bw = (bw + 1) % 512;
    end
    wr_valid = 0;
  endtask

  task automatic read_n(input int n);
    rd_ready = 1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (!solo && br == 511) begin
        exp_kind.push_back(1);
        exp_cyc.push_back(cyc);
      end
      br = (br + 1) % 512;
    end
    rd_ready = 0;
  endtask

  task automatic give(input bit kind);
    xin = 1; xin_kind = kind;
    @(posedge clk); #1;
    xin = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // Chained slice that is not first-loaded
    do_reset(1'b0, 1'b1);
    @(negedge clk);
    chk(!wr_ready, "R1 no write token", wr_ready, 0);
    chk(!rd_valid, "R1 no read offer", rd_valid, 0);
    chk(!xout, "R1 xout idle", xout, 0);
    @(posedge clk); #1;
    wr_valid = 1; rd_ready = 1;
    repeat (4) @(posedge clk);
    #1 wr_valid = 0; rd_ready = 0;
    @(negedge clk);
    chk(wr_addr == 0, "R7 write ignored", wr_addr, 0);
    chk(rd_addr == 0, "R7 read ignored", rd_addr, 0);
    @(posedge clk); #1;
    give(1'b0);
    @(negedge clk);
    chk(wr_ready, "R6 write token taken", wr_ready, 1);
    chk(!rd_valid, "R6 read token not taken", rd_valid, 0);
    @(posedge clk); #1;
    give(1'b1);
    write_n(512);
    @(negedge clk);
    chk(!wr_ready, "R4 token passed on", wr_ready, 0);
    chk(wr_addr == 0, "R2 write address wrap", wr_addr, 0);
    chk(rd_valid, "R6 read token offers", rd_valid, 1);
    @(posedge clk); #1;
    read_n(10);
    rt = 1;
    @(negedge clk);
    chk(rd_valid, "R9 chained retransmit no block", rd_valid, 1);
    @(posedge clk); #1;
    rt = 0;
    @(negedge clk);
    chk(rd_addr == 10, "R9 chained retransmit ignored", rd_addr, 10);
    @(posedge clk); #1;
    read_n(502);
    @(negedge clk);
    chk(!rd_valid, "R5 read token passed", rd_valid, 0);
    chk(rd_addr == 0, "R3 read address wrap", rd_addr, 0);
    repeat (3) @(negedge clk);
    chk(exp_kind.size() == 0, "R4/R5 all pulses seen", exp_kind.size(), 0);

    // First-loaded chained slice
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    chk(wr_ready, "R1 first slice writable", wr_ready, 1);
    chk(!rd_valid, "R1 first slice empty", rd_valid, 0);
    @(posedge clk); #1;
    write_n(3);
    @(negedge clk);
    chk(rd_valid, "R3 first slice read offer", rd_valid, 1);
    chk(wr_addr == 3, "R2 address step", wr_addr, 3);

    // Stand-alone slice
    do_reset(1'b1, 1'b1);
    @(negedge clk);
    chk(wr_ready, "R2 solo writable", wr_ready, 1);
    @(posedge clk); #1;
    write_n(256);
    @(negedge clk);
    chk(!xout, "R8 not over half at 256", xout, 0);
    @(posedge clk); #1;
    write_n(1);
    @(negedge clk);
    chk(xout, "R8 over half at 257", xout, 1);
    @(posedge clk); #1;
    read_n(1);
    @(negedge clk);
    chk(!xout, "R8 back to 256", xout, 0);
    chk(rd_addr == 1, "R3 solo read step", rd_addr, 1);
    @(posedge clk); #1;
    rt = 1;
    @(negedge clk);
    chk(!wr_ready && !rd_valid, "R9 strobes held during retransmit", {wr_ready, rd_valid}, 0);
    @(posedge clk); #1;
    rt = 0;
    @(negedge clk);
    chk(rd_addr == 0, "R9 read address rewound", rd_addr, 0);
    chk(xout, "R9 level reloaded to 257", xout, 1);
    @(posedge clk); #1;
    write_n(255);
    @(negedge clk);
    chk(!wr_ready, "R10 full after 512", wr_ready, 0);
    chk(wr_addr == 0, "R8 solo wrap without pulse", wr_addr, 0);
    chk(!xout_kind, "R8 solo kind", xout_kind, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule